// File: doc/BRIEF.md
# Three-Way Cache Miss Classifier

This block watches the access stream of a small cache from the side, together with the hit or miss result that the cache reports for each access. It sorts every miss into one of three kinds. A cold miss is the first reference to a block. A capacity miss is one that a fully-associative cache of the same size would also have taken. A conflict miss is any other miss, which only the cache's placement restriction caused. For each accepted access it reports a class code one cycle later, and it keeps a saturating count of each kind of miss. It is used for performance analysis: a designer places it beside a cache model or real cache and reads the three counts to decide whether more capacity or more associativity would help.

The default geometry is 8-bit byte addresses, 4-byte blocks and a 32-byte cache. That gives 64 distinct blocks and 8 frames. Internally the block keeps a one-bit "touched" record per block and a shadow recency stack with one entry per frame. The shadow stack behaves like a fully-associative cache with true LRU replacement. The reporting logic is a two-state machine. In ST_IDLE no result is pending. In ST_REPORT a class code is on the outputs. The transition ST_IDLE to ST_REPORT is taken on an accepted access. ST_REPORT stays in ST_REPORT when another access follows at once, and it returns to ST_IDLE on a cycle with no access.

Top module: `miss_sorter`

## Requirements
- R1: The block index of an access is acc_addr[7:2]; the two low address bits select a byte within the block and do not affect classification.
- R2: For each cycle with acc_valid high, cls_valid is high in the following cycle and cls_code carries the result. cls_code encodes 2'b00 hit, 2'b01 cold, 2'b10 capacity, 2'b11 conflict. When cls_valid is low, cls_code is 2'b00.
- R3: An access with acc_hit high is reported as 2'b00 and changes no counter.
- R4: A miss to a block that no earlier access since reset has referenced is cold (2'b01). Any access, hit or miss, marks its block as referenced.
- R5: A miss to a referenced block is capacity (2'b10) when at least 8 other distinct blocks were accessed since the previous access to that block.
- R6: A miss to a referenced block with fewer than 8 other distinct blocks accessed since its previous access is conflict (2'b11).
- R7: Every accepted access, hits included, makes its block the most recent for the distance measure of R5 and R6.
- R8: cnt_cold, cnt_cap and cnt_conf each increase by one for each miss of their kind, together with the cls_code report, and hold at 65535 once reached.
- R9: While acc_valid is low, acc_addr and acc_hit are ignored and no internal record changes.
- R10: Reset clears the counters, the referenced record and the recency stack, and drives cls_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 8 | Byte address of the access |
| acc_hit | input | 1 | The observed cache reported a hit |
| cls_valid | output | 1 | A class code is reported this cycle |
| cls_code | output | 2 | Class of the access accepted in the previous cycle |
| cnt_cold | output | 16 | Saturating count of cold misses |
| cnt_cap | output | 16 | Saturating count of capacity misses |
| cnt_conf | output | 16 | Saturating count of conflict misses |

## Verification
The bench probes the edge of the distance rule. A block revisited after exactly seven other distinct blocks must be conflict, and after exactly eight it must be capacity. An off-by-one in the stack depth or in its shift swaps these two results. A block that is refreshed by a hit in the middle of a window must then come back as conflict. A design that updates recency only on misses would call it capacity. The bench also checks that the byte offset is ignored, that accesses presented with acc_valid low leave the block unreferenced, so that its later miss is still cold, and that the capacity counter holds at 65535 after more than that many capacity misses. A design that wraps the counter to zero would show a small count there.

// File: rtl/miss_sorter_pkg.sv
package miss_sorter_pkg;

    typedef enum logic [1:0] {
        CLS_HIT  = 2'b00,
        CLS_COLD = 2'b01,
        CLS_CAP  = 2'b10,
        CLS_CONF = 2'b11
    } miss_class_t;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } report_state_t;

    localparam int NUM_CLASSES = 3;

endpackage

// File: rtl/touch_map.sv
module touch_map #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_touched,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] touched_q;

    assign rd_touched = touched_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touched_q <= '0;
        end else if (wr_en) begin
            touched_q[wr_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/recency_stack.sv
module recency_stack #(
    parameter int DEPTH = 8,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [TAG_W-1:0] tag_in,
    output logic             present
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [TAG_W-1:0] tag_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    match_pos;
    logic [PW-1:0]    shift_lim;

    for (genvar g = 0; g < DEPTH; g++) begin : g_match
        assign match[g] = vld_q[g] && (tag_q[g] == tag_in);
    end

    always_comb begin
        match_pos = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (match[k]) match_pos = PW'(k);
        end
    end

    assign present   = |match;
    // entries above the matched slot (or all, on absence) move down by one
    assign shift_lim = present ? match_pos : PW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q[0] <= 1'b0;
            tag_q[0] <= '0;
        end else if (upd) begin
            vld_q[0] <= 1'b1;
            tag_q[0] <= tag_in;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q[g] <= 1'b0;
                tag_q[g] <= '0;
            end else if (upd && (PW'(g) <= shift_lim)) begin
                vld_q[g] <= vld_q[g-1];
                tag_q[g] <= tag_q[g-1];
            end
        end
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && (count != {W{1'b1}})) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/miss_sorter.sv
module miss_sorter
    import miss_sorter_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int CACHE_BYTES = 32,
    parameter int BLOCK_BYTES = 4,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_hit,
    output logic              cls_valid,
    output logic [1:0]        cls_code,
    output logic [CNT_W-1:0]  cnt_cold,
    output logic [CNT_W-1:0]  cnt_cap,
    output logic [CNT_W-1:0]  cnt_conf
);
    localparam int OFF_W  = $clog2(BLOCK_BYTES);
    localparam int FRAMES = CACHE_BYTES / BLOCK_BYTES;
    localparam int BLK_W  = ADDR_W - OFF_W;

    report_state_t state_q, state_d;
    miss_class_t   verdict, code_q;
    logic [BLK_W-1:0] blk;
    logic was_touched, in_stack;
    logic [CNT_W-1:0] counts [NUM_CLASSES];

    assign blk = acc_addr[ADDR_W-1:OFF_W];

    touch_map #(.IDX_W(BLK_W)) u_touch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_idx     (blk),
        .rd_touched (was_touched),
        .wr_en      (acc_valid),
        .wr_idx     (blk)
    );

    recency_stack #(.DEPTH(FRAMES), .TAG_W(BLK_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd     (acc_valid),
        .tag_in  (blk),
        .present (in_stack)
    );

    // priority: hit, then cold, then capacity, then conflict
    always_comb begin
        if (acc_hit)           verdict = CLS_HIT;
        else if (!was_touched) verdict = CLS_COLD;
        else if (!in_stack)    verdict = CLS_CAP;
        else                   verdict = CLS_CONF;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (acc_valid)  state_d = ST_REPORT;
            ST_REPORT: if (!acc_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         code_q <= CLS_HIT;
        else if (acc_valid) code_q <= verdict;
        else                code_q <= CLS_HIT;
    end

    for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cnt
        logic bump;
        assign bump = acc_valid && (verdict == miss_class_t'(c + 1));
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (bump),
            .count (counts[c])
        );
    end

    assign cls_valid = (state_q == ST_REPORT);
    assign cls_code  = code_q;
    assign cnt_cold  = counts[0];
    assign cnt_cap   = counts[1];
    assign cnt_conf  = counts[2];
endmodule

// File: rtl/miss_sorter_chk.sv
module miss_sorter_chk #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_hit,
    input logic              cls_valid,
    input logic [1:0]        cls_code,
    input logic [CNT_W-1:0]  cnt_cold,
    input logic [CNT_W-1:0]  cnt_cap,
    input logic [CNT_W-1:0]  cnt_conf
);
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> cls_valid); // R2
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !cls_valid); // R2
    AST_IDLE_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cls_valid |-> (cls_code == 2'b00)); // R2
    AST_HIT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit) |=> (cls_code == 2'b00)); // R3
    AST_MISS_CLASSIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_hit) |=> (cls_code != 2'b00)); // R4
    AST_COLD_TRACKS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cold != $past(cnt_cold)) |-> (cls_code == 2'b01)); // R8
    AST_CAP_TRACKS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cap != $past(cnt_cap)) |-> (cls_code == 2'b10)); // R8
    AST_CONF_TRACKS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_conf != $past(cnt_conf)) |-> (cls_code == 2'b11)); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_cap >= $past(cnt_cap)) && (cnt_cold >= $past(cnt_cold))
        && (cnt_conf >= $past(cnt_conf))); // R8
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(cnt_cold) && $stable(cnt_cap) && $stable(cnt_conf))); // R9
endmodule

bind miss_sorter miss_sorter_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_hit   (acc_hit),
    .cls_valid (cls_valid),
    .cls_code  (cls_code),
    .cnt_cold  (cnt_cold),
    .cnt_cap   (cnt_cap),
    .cnt_conf  (cnt_conf)
);

// File: tb/miss_sorter_bench.sv
`timescale 1ns/1ps
module miss_sorter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic        acc_hit = 1'b0;
    logic        cls_valid;
    logic [1:0]  cls_code;
    logic [15:0] cnt_cold, cnt_cap, cnt_conf;

    always #4 clk = ~clk;

    miss_sorter u_miss_sorter (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .cls_valid(cls_valid), .cls_code(cls_code),
        .cnt_cold(cnt_cold), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
    );

    typedef struct {
        logic [1:0] code;
        int         c_cold, c_cap, c_conf;
        string      scen;
    } exp_t;

    exp_t  sb_q[$];
    int    checks = 0;
    int    errors = 0;
    string scen = "R4";

    // reference model, built from the requirements
    bit   seen_m [64];
    int   lru_m[$];
    bit   dm_v [8];
    int   dm_tag [8];
    int   e_cold, e_cap, e_conf;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string code_req(input logic [1:0] c);
        case (c)
            2'b00: return "R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model_clear();
        foreach (seen_m[i]) seen_m[i] = 1'b0;
        foreach (dm_v[i]) dm_v[i] = 1'b0;
        lru_m.delete();
        e_cold = 0; e_cap = 0; e_conf = 0;
    endtask

    // mode 0: hit from a direct-mapped 8-frame cache; 1: forced hit; 2: forced miss
    task automatic acc(input int blk, input int off, input int mode);
        bit   h, dm_h, inst;
        int   pos;
        logic [1:0] c;
        exp_t it;
        @(negedge clk);
        dm_h = dm_v[blk % 8] && (dm_tag[blk % 8] == blk / 8);
        h = (mode == 0) ? dm_h : (mode == 1);
        if (!dm_h) begin dm_v[blk % 8] = 1'b1; dm_tag[blk % 8] = blk / 8; end
        pos = -1;
        foreach (lru_m[i]) if (lru_m[i] == blk) pos = i;
        inst = (pos >= 0);
        if (h)               c = 2'b00;
        else if (!seen_m[blk]) c = 2'b01;
        else if (!inst)      c = 2'b10;
        else                 c = 2'b11;
        seen_m[blk] = 1'b1;
        if (inst) lru_m.delete(pos);
        lru_m.push_front(blk);
        if (lru_m.size() > 8) void'(lru_m.pop_back());
        if (c == 2'b01 && e_cold < 65535) e_cold++;
        if (c == 2'b10 && e_cap  < 65535) e_cap++;
        if (c == 2'b11 && e_conf < 65535) e_conf++;
        it.code = c; it.c_cold = e_cold; it.c_cap = e_cap; it.c_conf = e_conf;
        it.scen = scen;
        sb_q.push_back(it);
        acc_valid = 1'b1;
        acc_addr  = 8'((blk << 2) | (off & 3));
        acc_hit   = h;
    endtask

    // inputs wiggle while acc_valid is low; nothing may be recorded
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            acc_valid = 1'b0;
            acc_addr  = 8'(8'hC4 + i * 4);
            acc_hit   = i[0];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; acc_valid = 1'b0;
        model_clear();
        sb_q.delete();
        repeat (2) @(negedge clk);
        chk(cls_valid == 1'b0, "R10", "cls_valid in reset", cls_valid, 0);
        chk(cnt_cold == 0, "R10", "cnt_cold in reset", cnt_cold, 0);
        chk(cnt_cap  == 0, "R10", "cnt_cap in reset",  cnt_cap, 0);
        chk(cnt_conf == 0, "R10", "cnt_conf in reset", cnt_conf, 0);
        rst_n = 1'b1;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && cls_valid) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R2", "result with nothing pending", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(cls_code == e.code, code_req(e.code),
                    {"class code (", e.scen, ")"}, cls_code, e.code);
                chk(cnt_cold == e.c_cold, "R8", {"cnt_cold (", e.scen, ")"}, cnt_cold, e.c_cold);
                chk(cnt_cap  == e.c_cap,  "R8", {"cnt_cap (", e.scen, ")"},  cnt_cap, e.c_cap);
                chk(cnt_conf == e.c_conf, "R8", {"cnt_conf (", e.scen, ")"}, cnt_conf, e.c_conf);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_clear();
        do_reset();

        // R4: first touches are cold; DM cache gives realistic hits
        scen = "R4";
        for (int b = 0; b < 4; b++) acc(b, 0, 0);
        acc(1, 2, 0);
        // R4: a hit on a new block marks it referenced, later miss is not cold
        acc(20, 0, 1);
        acc(20, 0, 2);
        idle(3);
        // R2: idle result state
        chk(cls_valid == 1'b0, "R2", "cls_valid when idle", cls_valid, 0);
        chk(cls_code == 2'b00, "R2", "cls_code when idle", cls_code, 0);

        // R1: different byte offset within one block counts as the same block
        scen = "R1";
        acc(30, 0, 2);
        acc(30, 3, 2);

        // R6: exactly 7 distinct blocks between -> conflict
        scen = "R6";
        acc(50, 1, 2);
        for (int b = 0; b < 7; b++) acc(b + 1, 0, 0);
        acc(50, 0, 2);
        // R5: exactly 8 distinct blocks between -> capacity
        scen = "R5";
        for (int b = 0; b < 8; b++) acc(b + 8, 0, 0);
        acc(50, 2, 2);

        // R7: a hit mid-window refreshes recency
        scen = "R7";
        acc(60, 0, 2);
        for (int b = 0; b < 7; b++) acc(b + 16, 0, 0);
        acc(60, 0, 1);
        for (int b = 0; b < 7; b++) acc(b + 24, 0, 0);
        acc(60, 0, 2);

        // conflict pattern through the DM cache: same frame, alternate tags
        scen = "R6";
        for (int k = 0; k < 6; k++) acc((k % 2) ? 37 : 45, 0, 0);

        // R9: block touched only while acc_valid is low stays unreferenced
        scen = "R9";
        idle(4);
        chk(cls_valid == 1'b0, "R9", "cls_valid while idle", cls_valid, 0);
        acc(49, 0, 2);   // 0xC4 was presented idle; block 49 must still be cold
        idle(2);

        // R8: saturation of the capacity counter (9 blocks cycled, all misses)
        scen = "R8";
        for (int n = 0; n < 65545; n++) acc(40 + (n % 9), 0, 2);
        idle(2);
        chk(cnt_cap == 16'hFFFF, "R8", "cnt_cap saturated", cnt_cap, 65535);

        // R10: reset clears the referenced record too
        do_reset();
        scen = "R10";
        acc(50, 0, 2);
        idle(2);
        chk(sb_q.size() == 0, "R2", "results outstanding", sb_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule